// File: doc/BRIEF.md
# Serial Byte Receiver with Peripheral Handover

This block collects a serial bit stream, one bit per rising edge of its single receive clock, and assembles it into bytes. Each bit first passes through an input shift register of `W` stages and then moves into a receive buffer of the same width. The buffer is always visible on the parallel output. The first bit of a byte ends up in the most significant bit. With a fresh pipeline, the first byte is complete 16 accepted clocks after its first bit is sampled. Later bytes complete every 8 accepted clocks.

When the buffer becomes complete and the peripheral is requesting data, the byte is handed over at once and reception continues without a break. If no request is present, the block enters a held state. In the held state it raises the full flag, drops the ready flag, freezes both registers and discards every arriving bit until a request releases the byte. An active-low enable pauses reception without losing any state.

The controller has three states. `RX_PRIME` loads the first `W` bits into the input register. `RX_STREAM` moves bits on into the buffer. `RX_HELD` means the buffer is complete and waiting for a request. The transitions are:
- prime-done: `RX_PRIME` to `RX_STREAM` after `W` accepted bits.
- fill-handover: stay in `RX_STREAM` when the buffer completes while the request is high.
- fill-hold: `RX_STREAM` to `RX_HELD` when the buffer completes without a request.
- release: `RX_HELD` to `RX_STREAM` on a request.

Top module: `serial_rx_handshake`

## Requirements
- R1: After reset, `rx_data` is 0, `rx_full` is 0, `rx_ready` is 1 and `xfer_valid` is 0.
- R2: Bits are sampled on each accepted rising edge. The first bit sampled after reset reaches `rx_data[7]` on the 16th accepted edge. At that point `rx_data` holds the first 8 bits, with the earliest bit in bit 7.
- R3: On the edge that completes the buffer while `periph_req` is low, `rx_full` rises and `rx_ready` falls. Both change together, in the cycle after that edge.
- R4: While `rx_full` is high and `periph_req` is low, `rx_data` does not change, `rx_full` stays high, and the bits on `rx_bit` are discarded. These discarded bits never appear in any later byte.
- R5: An edge that sees `rx_full` high and `periph_req` high hands the byte over. In the following cycle, `xfer_valid` is 1, `rx_data` still shows the byte and `rx_full` is 0. The bit count restarts, so the next byte completes after 8 more accepted edges.
- R6: If `periph_req` is high on the edge that completes the buffer, the byte is handed over. `xfer_valid` is 1 in the next cycle, `rx_full` stays 0 and `rx_ready` stays 1, and the next bit is accepted.
- R7: A request while the buffer is not complete delivers nothing (`xfer_valid` stays 0), and shifting continues.
- R8: While `rx_en_n` is 1, no bit is sampled, `rx_data` holds and the bit count does not advance.
- R9: With the request held high, consecutive bytes are handed over every 8 accepted edges.
- R10: `rx_ready` is always the inverse of `rx_full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_bit | input | 1 | Serial data bit |
| rx_en_n | input | 1 | Reception enable, active low |
| periph_req | input | 1 | Peripheral request for data, active high |
| rx_data | output | 8 | Receive buffer contents |
| xfer_valid | output | 1 | One-cycle strobe: `rx_data` is handed to the peripheral |
| rx_full | output | 1 | Buffer complete and waiting for a request |
| rx_ready | output | 1 | Sender may send bits |

## Verification
The checker watches, on every cycle, the properties that need only one or two cycles of context:
- The two flags stay complementary.
- The buffer freezes while the block is held or disabled.
- A request releases a held byte with a strobe.
- A strobe never coincides with the full flag.
- The full flag never rises on an edge that saw a request.

Some behaviours span long windows, and only the bench scenarios can show them:
- The 16-edge first-byte latency and the MSB-first bit order.
- Bits discarded during a stall never appearing in a later byte.
- The 8-edge spacing of handed-over bytes.
- The bit count not advancing while disabled.

// File: rtl/rxh_pkg.sv
package rxh_pkg;

    typedef enum logic [1:0] {
        RX_PRIME  = 2'd0,
        RX_STREAM = 2'd1,
        RX_HELD   = 2'd2
    } rx_state_e;

endpackage

// File: rtl/rxh_shift_path.sv
module rxh_shift_path #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] buf_q
);
    logic [W-1:0] stage_q;

    // input register: one flop per stage, stage 0 takes the line
    generate
        for (genvar g = 0; g < W; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= 1'b0;
                end else if (shift_en) begin
                    if (g == 0) begin
                        stage_q[g] <= bit_in;
                    end else begin
                        stage_q[g] <= stage_q[g-1];
                    end
                end
            end
        end
    endgenerate

    // receive buffer fed from the last input stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else if (shift_en) begin
            buf_q <= {buf_q[W-2:0], stage_q[W-1]};
        end
    end

endmodule

// File: rtl/rxh_ctrl.sv
module rxh_ctrl
    import rxh_pkg::*;
#(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_n,
    input  logic req,
    output logic shift_en,
    output logic held,
    output logic xfer_q
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    rx_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          accept;
    logic          handover;

    assign accept = !en_n && (state_q != RX_HELD);

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        handover = 1'b0;
        unique case (state_q)
            RX_PRIME: begin
                if (accept) begin
                    if (cnt_q == LAST) begin
                        state_d = RX_STREAM;       // prime-done
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            RX_STREAM: begin
                if (accept) begin
                    if (cnt_q == LAST) begin
                        cnt_d = '0;
                        if (req) begin
                            handover = 1'b1;       // fill-handover
                        end else begin
                            state_d = RX_HELD;     // fill-hold
                        end
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            RX_HELD: begin
                if (req) begin
                    handover = 1'b1;               // release
                    state_d  = RX_STREAM;
                    cnt_d    = '0;
                end
            end
            default: begin
                state_d = RX_PRIME;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_PRIME;
            cnt_q   <= '0;
            xfer_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            xfer_q  <= handover;
        end
    end

    always_comb begin
        shift_en = accept;
        held     = (state_q == RX_HELD);
    end

endmodule

// File: rtl/serial_rx_handshake.sv
module serial_rx_handshake #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rx_bit,
    input  logic         rx_en_n,
    input  logic         periph_req,
    output logic [W-1:0] rx_data,
    output logic         xfer_valid,
    output logic         rx_full,
    output logic         rx_ready
);
    logic shift_en;
    logic held;

    rxh_ctrl #(.W(W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_n     (rx_en_n),
        .req      (periph_req),
        .shift_en (shift_en),
        .held     (held),
        .xfer_q   (xfer_valid)
    );

    rxh_shift_path #(.W(W)) u_path (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .bit_in   (rx_bit),
        .buf_q    (rx_data)
    );

    assign rx_full  = held;
    assign rx_ready = !held;

endmodule

// File: rtl/serial_rx_handshake_chk.sv
module serial_rx_handshake_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         rx_bit,
    input logic         rx_en_n,
    input logic         periph_req,
    input logic [W-1:0] rx_data,
    input logic         xfer_valid,
    input logic         rx_full,
    input logic         rx_ready
);
    // R10
    a_r10_flags_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready == !rx_full);

    // R4
    a_r4_frozen_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |=> $stable(rx_data));

    // R4
    a_r4_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !periph_req) |=> rx_full);

    // R5
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && periph_req) |=> (xfer_valid && !rx_full));

    // R5, R6
    a_r6_strobe_not_full: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> !rx_full);

    // R3, R6
    a_r3_full_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> !$past(periph_req));

    // R8
    a_r8_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en_n |=> $stable(rx_data));

    // R7
    a_r7_strobe_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> $past(periph_req));

endmodule

bind serial_rx_handshake serial_rx_handshake_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_bit     (rx_bit),
    .rx_en_n    (rx_en_n),
    .periph_req (periph_req),
    .rx_data    (rx_data),
    .xfer_valid (xfer_valid),
    .rx_full    (rx_full),
    .rx_ready   (rx_ready)
);

// File: tb/serial_rx_handshake_bench.sv
`timescale 1ns/1ps
module serial_rx_handshake_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_bit = 1'b0;
    logic       rx_en_n = 1'b1;
    logic       periph_req = 1'b0;
    logic [7:0] rx_data;
    logic       xfer_valid, rx_full, rx_ready;

    int  n_tests = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    serial_rx_handshake u_serial_rx_handshake (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_en_n(rx_en_n),
        .periph_req(periph_req), .rx_data(rx_data), .xfer_valid(xfer_valid),
        .rx_full(rx_full), .rx_ready(rx_ready)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic edge_in(input logic b, input logic en_n, input logic req);
        @(negedge clk);
        rx_bit = b; rx_en_n = en_n; periph_req = req;
        @(posedge clk);
        #1;
    endtask

    task automatic flags(input string tag, input int full, input int xfer);
        chk({tag, " full"}, rx_full, full);
        chk({tag, " ready"}, rx_ready, !full);
        chk({tag, " xfer"}, xfer_valid, xfer);
    endtask

    task automatic t_reset();
        #1;
        chk("R1 data", rx_data, 0);
        flags("R1", 0, 0);
    endtask

    // two bytes in, no request: first byte complete at edge 16
    task automatic t_first_byte();
        for (int i = 7; i >= 0; i--) edge_in(8'hA5 >> i, 1'b0, 1'b0);
        for (int i = 7; i > 0; i--) edge_in(8'h3C >> i, 1'b0, 1'b0);
        chk("R2 partial", rx_data, 8'hA5 >> 1);
        flags("R3 before fill", 0, 0);
        edge_in(1'b0, 1'b0, 1'b0);
        chk("R2 first byte", rx_data, 8'hA5);
        flags("R3 fill", 1, 0);
    endtask

    // stall: arriving bits dropped
    task automatic t_stall();
        for (int i = 0; i < 5; i++) begin
            edge_in(i[0], 1'b0, 1'b0);
            chk("R4 hold data", rx_data, 8'hA5);
            flags("R4 hold", 1, 0);
        end
    endtask

    // release, then second byte fills untouched by dropped bits
    task automatic t_release();
        edge_in(1'b1, 1'b0, 1'b1);
        chk("R5 data", rx_data, 8'hA5);
        flags("R5 release", 0, 1);
        for (int i = 7; i > 0; i--) begin
            edge_in(8'h96 >> i, 1'b0, 1'b0);
            chk("R5 no strobe", xfer_valid, 0);
        end
        chk("R5 count restart", rx_full, 0);
        edge_in(1'b0, 1'b0, 1'b0);
        chk("R4 no dropped bits", rx_data, 8'h3C);
        flags("R5 refill", 1, 0);
        edge_in(1'b0, 1'b0, 1'b1);
        flags("R5 second release", 0, 1);
    endtask

    // request held: no strobe before fill, handover on fill, next bytes every 8
    task automatic t_stream();
        for (int i = 7; i > 0; i--) begin
            edge_in(8'h5A >> i, 1'b0, 1'b1);
            flags("R7 early request", 0, 0);
        end
        edge_in(1'b0, 1'b0, 1'b1);
        chk("R6 data", rx_data, 8'h96);
        flags("R6 fill handover", 0, 1);
        for (int i = 7; i > 0; i--) begin
            edge_in(8'hC3 >> i, 1'b0, 1'b1);
            flags("R9 gap", 0, 0);
        end
        edge_in(1'b1, 1'b0, 1'b1);
        chk("R9 next byte", rx_data, 8'h5A);
        flags("R9 spacing", 0, 1);
    endtask

    // enable high pauses sampling and the count
    task automatic t_enable();
        logic [7:0] snap;
        snap = rx_data;
        for (int i = 0; i < 4; i++) begin
            edge_in(i[0], 1'b1, 1'b0);
            chk("R8 data held", rx_data, snap);
            flags("R8 paused", 0, 0);
        end
        for (int i = 7; i > 0; i--) edge_in(1'b0, 1'b0, 1'b0);
        chk("R8 count frozen", rx_full, 0);
        edge_in(1'b0, 1'b0, 1'b0);
        chk("R8 byte", rx_data, 8'hC3);
        flags("R8 fill", 1, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_first_byte();
        t_stall();
        t_release();
        t_stream();
        t_enable();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule